// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A two-bit address chooses one of three channel data ports or a shared control port. Writes to the control port either program a channel, freeze its count, or issue a multi-channel read-back that can freeze counts and status bytes at the same moment. Writes to a data port deliver count bytes. Reads from a data port return a frozen status byte, a frozen count, or the live count, one byte per strobe.

Each channel keeps its own byte access mode and its own low/high byte ordering for reads and for writes. Each channel also has a small counting core, kept deliberately simple. The core takes a newly written count on its next tick and counts down on later ticks. It drives an output level and a flag that shows a count is still waiting to be loaded.

Bus strobes are single-cycle, and at most one of read and write is high in any cycle. Read data is combinational and valid in the cycle of the read strobe. Reset is asynchronous and active-low, and its release is synchronised inside the block over two clock edges.

Top module: `timer_regif`

## Requirements
- R1: Addresses 0, 1 and 2 reach the data ports of channels 0, 1 and 2; address 3 is the control port. A read at address 3 returns 0x00 and changes no channel state.
- R2: Control word fields are: bits 7:6 channel, bits 5:4 access mode, bits 3:1 counting mode, bit 0 BCD. A programmed counting mode of 6 or 7 is stored as 2 or 3.
- R3: Access mode 00 freezes the selected channel's current count. The command is ignored while that channel already holds a frozen count.
- R4: Access mode 01 moves only the low byte: a write loads {0x00, byte} and reads return the low byte. Access mode 10 moves only the high byte: a write loads {byte, 0x00} and reads return the high byte. Neither mode alternates.
- R5: In access mode 11 the first written byte is held, and the 16-bit count {second, first} is loaded only when the second byte arrives. Live reads alternate between the low byte and the high byte.
- R6: A control word with a nonzero access mode restarts that channel's read ordering and write ordering at the low byte.
- R7: A control word with channel field 11 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes each selected count and bit 4 low freezes each selected status. A freeze already held is kept.
- R8: The status byte is {output level, null-count flag, access mode[1:0], counting mode[2:0], BCD}, from bit 7 down to bit 0.
- R9: A data read returns the frozen status if one is held and releases it. Otherwise it returns the frozen count if one is held, and otherwise the live count.
- R10: A frozen count in mode 11 is read as the low byte and then the high byte, and is then released. In modes 01 and 10 it is released after one read.
- R11: A count written to a channel reaches its core on the channel's next tick. The null-count flag rises on a count write or a control write and clears when the core loads. Each further tick decrements the count, and the output level is high while the count is zero. A tick in the same cycle as a write to that channel is not applied.
- R12: After reset every channel is in access mode 11, counting mode 0, BCD 0, with no frozen values, count 0, output level high and null-count flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Port select: 0 to 2 data ports, 3 control |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the cycle of rd_en |
| tick | input | 3 | Per-channel counting tick for the cores |
| ch_out | output | 3 | Per-channel output level |

## Verification
The assertions check the following on every cycle:
- a frozen status is released by the read that returns it;
- a frozen count and its read mode stay unchanged until a read;
- a first word-mode byte is held without loading;
- a programming write restarts byte ordering;
- a core that loads on a tick clears its null-count flag;
- a control-port read returns zero.

The bench scenarios show the byte values themselves. These include status encodings, the fold of counting modes 6 and 7, the precedence of status over count, a second freeze being ignored, a read-back that covers two channels, and the output level reaching zero.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] SEL_RB   = 2'b11;

  // modes 6 and 7 alias modes 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

endpackage

// File: rtl/timer_chan_core.sv
module timer_chan_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          ctl_wr,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          out_lvl,
  output logic          null_cnt
);

  logic [CW-1:0] hold_q, hold_d, ce_q, ce_d;
  logic          pend_q, pend_d, null_q, null_d;
  logic          en;

  assign en = load_en | ctl_wr | tick;

  always_comb begin
    hold_d = hold_q;
    ce_d   = ce_q;
    pend_d = pend_q;
    null_d = null_q;
    if (load_en) begin
      hold_d = load_val;
      pend_d = 1'b1;
      null_d = 1'b1;
    end else if (ctl_wr) begin
      pend_d = 1'b0;
      null_d = 1'b1;
    end else if (tick) begin
      if (pend_q) begin
        ce_d   = hold_q;
        pend_d = 1'b0;
        null_d = 1'b0;
      end else begin
        ce_d = ce_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ce_q   <= '0;
      pend_q <= 1'b0;
      null_q <= 1'b0;
    end else if (en) begin
      hold_q <= hold_d;
      ce_q   <= ce_d;
      pend_q <= pend_d;
      null_q <= null_d;
    end
  end

  assign count    = ce_q;
  assign out_lvl  = (ce_q == '0);
  assign null_cnt = null_q;

  // R11: a tick with a waiting count loads it and clears the null flag
  assert_core_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q && !load_en && !ctl_wr) |=> (!null_cnt && count == $past(hold_q)));

  // R11: a count write raises the null flag
  assert_core_null_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> null_cnt);

endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
  import timer_regif_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  acc_e          ctl_acc,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_bcd,
  input  logic          cnt_latch,
  input  logic          sts_latch,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] live_cnt,
  input  logic          live_out,
  input  logic          null_cnt,
  output logic [DW-1:0] rdata,
  output logic          load_en,
  output logic [CW-1:0] load_val
);

  acc_e          acc_q, acc_d, cl_q, cl_d;
  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d, rd_hi_q, rd_hi_d, wr_hi_q, wr_hi_d, sl_q, sl_d;
  logic [DW-1:0] wlat_q, wlat_d, sts_q, sts_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = ctl_wr | cnt_latch | sts_latch | data_wr | data_rd;

  always_comb begin
    acc_d   = acc_q;   mode_d = mode_q;   bcd_d = bcd_q;
    rd_hi_d = rd_hi_q; wr_hi_d = wr_hi_q; wlat_d = wlat_q;
    cl_d    = cl_q;    cnt_d  = cnt_q;    sl_d  = sl_q;  sts_d = sts_q;
    load_en  = 1'b0;
    load_val = '0;
    if (ctl_wr) begin
      acc_d   = ctl_acc;
      mode_d  = fold_mode(ctl_mode);
      bcd_d   = ctl_bcd;
      rd_hi_d = 1'b0;
      wr_hi_d = 1'b0;
    end
    if (cnt_latch && cl_q == ACC_NONE) begin
      cnt_d = live_cnt;
      cl_d  = acc_q;
    end
    if (sts_latch && !sl_q) begin
      sts_d = DW'({live_out, null_cnt, acc_q, mode_q, bcd_q});
      sl_d  = 1'b1;
    end
    if (data_wr) begin
      case (acc_q)
        ACC_HI: begin
          load_en  = 1'b1;
          load_val = {wdata, {DW{1'b0}}};
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            wlat_d  = wdata;
            wr_hi_d = 1'b1;
          end else begin
            load_en  = 1'b1;
            load_val = {wdata, wlat_q};
            wr_hi_d  = 1'b0;
          end
        end
        default: begin
          load_en  = 1'b1;
          load_val = {{DW{1'b0}}, wdata};
        end
      endcase
    end
    if (data_rd) begin
      if (sl_q) begin
        sl_d = 1'b0;
      end else if (cl_q != ACC_NONE) begin
        cl_d = (cl_q == ACC_WORD) ? ACC_HI : ACC_NONE;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end
  end

  always_comb begin
    if (sl_q)
      rdata = sts_q;
    else if (cl_q != ACC_NONE)
      rdata = (cl_q == ACC_HI) ? cnt_q[CW-1:DW] : cnt_q[DW-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
      rdata = live_cnt[CW-1:DW];
    else
      rdata = live_cnt[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_WORD; mode_q  <= '0;   bcd_q  <= 1'b0;
      rd_hi_q <= 1'b0;     wr_hi_q <= 1'b0; wlat_q <= '0;
      cl_q    <= ACC_NONE; cnt_q   <= '0;   sl_q   <= 1'b0; sts_q <= '0;
    end else if (en) begin
      acc_q   <= acc_d;   mode_q  <= mode_d;  bcd_q  <= bcd_d;
      rd_hi_q <= rd_hi_d; wr_hi_q <= wr_hi_d; wlat_q <= wlat_d;
      cl_q    <= cl_d;    cnt_q   <= cnt_d;   sl_q   <= sl_d;  sts_q <= sts_d;
    end
  end

  // R9: the read that returns a frozen status releases it
  assert_sts_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && sl_q && !sts_latch) |=> !sl_q);

  // R3: a frozen count is kept until it is read
  assert_cnt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q != ACC_NONE && !data_rd) |=> ($stable(cnt_q) && cl_q == $past(cl_q)));

  // R5: the first byte in word mode is held and nothing is loaded
  assert_word_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && acc_q == ACC_WORD && !wr_hi_q && !ctl_wr) |=> (wr_hi_q && wlat_q == $past(wdata)));

  // R6: programming restarts byte ordering
  assert_seq_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!rd_hi_q && !wr_hi_q));

  // R10: a frozen word count moves on to its high byte after one read
  assert_word_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !sl_q && cl_q == ACC_WORD && !cnt_latch) |=> cl_q == ACC_HI);

endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import timer_regif_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 3,
  localparam int CW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] tick,
  output logic [NCH-1:0] ch_out
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic       is_ctl, is_rb;
  logic [1:0] sel;
  acc_e       acc;

  assign is_ctl = wr_en && (addr == CTL_ADDR);
  assign sel    = wdata[7:6];
  assign acc    = acc_e'(wdata[5:4]);
  assign is_rb  = (sel == SEL_RB);

  logic [DW-1:0] ch_rdata [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          ctl_wr, cnt_latch, sts_latch, data_wr, data_rd;
    logic          load_en, out_lvl, null_cnt;
    logic [CW-1:0] load_val, live_cnt;

    assign ctl_wr    = is_ctl && !is_rb && (sel == 2'(i)) && (acc != ACC_NONE);
    assign cnt_latch = is_ctl && ((!is_rb && sel == 2'(i) && acc == ACC_NONE)
                                  || (is_rb && wdata[i+1] && !wdata[5]));
    assign sts_latch = is_ctl && is_rb && wdata[i+1] && !wdata[4];
    assign data_wr   = wr_en && (addr == 2'(i));
    assign data_rd   = rd_en && (addr == 2'(i));

    timer_chan_regs #(.DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ctl_wr   (ctl_wr),
      .ctl_acc  (acc),
      .ctl_mode (wdata[3:1]),
      .ctl_bcd  (wdata[0]),
      .cnt_latch(cnt_latch),
      .sts_latch(sts_latch),
      .data_wr  (data_wr),
      .data_rd  (data_rd),
      .wdata    (wdata),
      .live_cnt (live_cnt),
      .live_out (out_lvl),
      .null_cnt (null_cnt),
      .rdata    (ch_rdata[i]),
      .load_en  (load_en),
      .load_val (load_val)
    );

    timer_chan_core #(.CW(CW)) u_core (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load_en (load_en),
      .load_val(load_val),
      .ctl_wr  (ctl_wr),
      .tick    (tick[i]),
      .count   (live_cnt),
      .out_lvl (out_lvl),
      .null_cnt(null_cnt)
    );

    assign ch_out[i] = out_lvl;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++)
      if (rd_en && addr == 2'(k)) rdata = ch_rdata[k];
  end

  // R1: the control port never returns data
  assert_ctl_read_empty_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && addr == CTL_ADDR) |-> (rdata == '0));

endmodule

// File: tb/tb_timer_regif.sv
module tb_timer_regif;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 63;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] tick;
  logic [2:0] ch_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_regif dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick(tick), .ch_out(ch_out)
  );

  // {op, addr, data, req}: op 0 write, 1 read and compare, 2 tick mask, 3 compare ch_out
  localparam logic [19:0] VEC [NV] = '{
    20'h0_3_34_2, // R2 ch0 word mode, mode 2
    20'h0_0_34_5, // R5 low byte held
    20'h0_0_12_5, // R5 count 0x1234 loaded
    20'h0_3_E2_7, // R7 read-back status ch0
    20'h1_0_F4_8, // R8 out 1, null 1, acc 3, mode 2
    20'h2_0_01_B, // R11 core takes 0x1234
    20'h1_0_34_5, // R5 live low
    20'h1_0_12_5, // R5 live high
    20'h0_3_00_3, // R3 freeze 0x1234
    20'h2_0_01_B,
    20'h2_0_01_B, // R11 count now 0x1232
    20'h0_3_00_3, // R3 second freeze ignored
    20'h1_0_34_A, // R10 frozen low
    20'h1_0_12_A, // R10 frozen high
    20'h1_0_32_A, // R10 released, live low
    20'h1_0_12_5,
    20'h0_3_C2_7, // R7 read-back count and status ch0
    20'h1_0_34_9, // R9 status first
    20'h1_0_32_9, // R9 then frozen count
    20'h1_0_12_9,
    20'h0_3_50_4, // R4 ch1 low-only
    20'h0_1_AB_4,
    20'h2_0_02_B,
    20'h1_1_AB_4, // R4 no alternation
    20'h1_1_AB_4,
    20'h0_3_40_3, // R3 freeze ch1
    20'h2_0_02_B,
    20'h1_1_AB_A, // R10 one read releases
    20'h1_1_AA_A,
    20'h0_3_AE_2, // R2 ch2 high-only, mode 7
    20'h0_2_56_4, // R4 loads 0x5600
    20'h2_0_04_B,
    20'h0_3_E8_7, // R7 status ch2
    20'h1_2_26_2, // R2 mode 7 stored as 3
    20'h1_2_56_4,
    20'h0_3_80_3,
    20'h2_0_04_B,
    20'h1_2_56_A,
    20'h1_2_55_A,
    20'h0_3_30_6, // R6 ch0 reprogram
    20'h0_0_11_6, // first byte pending
    20'h0_3_31_6, // R6 write order restarts
    20'h0_0_22_6,
    20'h0_0_33_6,
    20'h2_0_01_B,
    20'h1_0_22_6,
    20'h0_3_30_6, // R6 read order restarts
    20'h1_0_22_6,
    20'h1_0_33_6,
    20'h0_3_E2_B, // R11 control write raised null
    20'h1_0_70_B,
    20'h1_3_00_1, // R1 control port read empty
    20'h1_0_22_1, // R1 ch0 ordering untouched
    20'h0_1_02_B,
    20'h2_0_02_B,
    20'h3_0_00_B, // R11 all outputs low
    20'h2_0_02_B,
    20'h2_0_02_B,
    20'h3_0_02_B, // R11 ch1 reached zero
    20'h0_3_DC_7, // R7 freeze counts of ch1 and ch2
    20'h1_1_00_7,
    20'h1_2_55_7,
    20'h1_0_33_7
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [19:0] v);
    logic [3:0] op;
    op = v[19:16];
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tick = '0;
    addr  = v[13:12];
    wdata = v[11:4];
    case (op)
      4'h0: wr_en = 1'b1;
      4'h1: begin
        rd_en = 1'b1;
        #1 check("read", int'(v[3:0]), rdata, v[11:4]);
      end
      4'h2: tick = v[6:4];
      default: begin
        #1 check("ch_out", int'(v[3:0]), {5'b0, ch_out}, v[11:4]);
      end
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tick = '0;
  endtask

  // R12 reset state
  task automatic check_reset();
    run_vec(20'h3_0_07_C);
    run_vec(20'h1_0_00_C);
    run_vec(20'h1_0_00_C);
    run_vec(20'h0_3_E2_C);
    run_vec(20'h1_0_B0_C);
    idle();
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = '0; addr = '0; wdata = '0;
    apply_reset();
    check_reset();
    for (int n = 0; n < NV; n++) run_vec(VEC[n]);
    idle();
    apply_reset();
    check_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule